// File: doc/BRIEF.md
# Memory-Mapped Display Register Window Bridge

This block sits behind a 4 KiB memory-mapped register window and routes each bus access to one of three back ends. One region maps onto the legacy display I/O ports 0x3C0 to 0x3DF. Wide accesses to that region are broken into byte operations, issued lowest byte first. Because of this order, a single 16-bit write can load an index port and then the data port next to it.

A second region maps a file of eleven 16-bit mode registers. The register number is taken from the address. For each access, the bridge first pulses the register number to the back end and then performs one 16-bit data transfer.

A third, optional region holds two 32-bit extension words. One reports the size of the extension block. The other selects the framebuffer byte order, and only two magic patterns change it.

The bus side takes a one-cycle request. It answers with a one-cycle ready pulse, which is raised only after every back-end operation of the access has been acknowledged. The requester must not issue a new request until that pulse has been seen. The read data is valid only for reads.

Top module: `mmio_win_bridge`

## Requirements
- R1: After reset, `rsp_ready`, `lp_req`, `mr_idx_wr` and `mr_req` are low and `big_endian` is 0, so the byte-order word reads 0x1E1E1E1E.
- R2: The legacy region covers window offsets 0x400 to 0x41F. A byte access (`req_size`=0) at offset 0x400+k performs exactly one byte operation on port 0x3C0+k. A byte read returns that port's value in bits 7:0 and zero in bits 31:8.
- R3: A halfword write (`req_size`=1) to the legacy region performs two byte writes, in this order: port N with `req_wdata[7:0]` first, then port N+1 with `req_wdata[15:0]`'s upper byte. Each operation holds `lp_port` and `lp_wdata` steady until `lp_ack`.
- R4: A halfword read from the legacy region returns port N in bits 7:0 and port N+1 in bits 15:8, with zero in the bits above.
- R5: A word access (`req_size`=2) to the legacy region performs four byte operations on ports N, N+1, N+2 and N+3, in ascending order. Byte k carries `req_wdata[8k+7:8k]`, and a read assembles the bytes in the same positions. An access whose last byte would fall past offset 0x41F is treated as unmapped.
- R6: The mode region covers offsets 0x500 to 0x515. Any access there first pulses `mr_idx_wr` for one cycle with `mr_idx` = (offset−0x500)>>1, and then raises `mr_req` for a single 16-bit transfer. A write sends `req_wdata[15:0]`. A read returns the back-end value zero-extended.
- R7: A word read at offset 0x600 returns 8. Writes to offset 0x600 are ignored.
- R8: The word at offset 0x604 reads 0xBEBEBEBE when `big_endian` is 1 and 0x1E1E1E1E when it is 0. Writing exactly 0xBEBEBEBE sets `big_endian`, writing exactly 0x1E1E1E1E clears it, and any other value leaves it unchanged.
- R9: The extension region responds only to word accesses at 0x600 or 0x604, and only while `ext_en` is 1. Any other access there reads zero and changes nothing.
- R10: `rev_id` is 2 while `ext_en` is 1 and DEF_REV (default 1) while it is 0.
- R11: An access to any other offset (including `req_size`=3) reads zero, starts no back-end operation, and answers with `rsp_ready` in the cycle after the request.
- R12: `rsp_ready` is a single-cycle pulse, raised only after the final back-end acknowledge of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_ready | output | 1 | Access complete pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| ext_en | input | 1 | Enables the extension region |
| rev_id | output | 8 | Device revision |
| big_endian | output | 1 | Framebuffer byte-order selection |
| lp_req | output | 1 | Legacy port byte operation request |
| lp_we | output | 1 | Legacy operation is a write |
| lp_port | output | 10 | Legacy port number |
| lp_wdata | output | 8 | Legacy write byte |
| lp_ack | input | 1 | Legacy operation done |
| lp_rdata | input | 8 | Legacy read byte, valid with `lp_ack` |
| mr_idx_wr | output | 1 | Mode register number strobe |
| mr_idx | output | 4 | Mode register number |
| mr_req | output | 1 | Mode data transfer request |
| mr_we | output | 1 | Mode transfer is a write |
| mr_wdata | output | 16 | Mode write data |
| mr_ack | input | 1 | Mode transfer done |
| mr_rdata | input | 16 | Mode read data, valid with `mr_ack` |

## Verification
The bench goes after the byte order of split legacy accesses. A design that issued the high byte first would load a data port before its index, and the logged port sequence would come out descending. It probes the edges of each region, 0x41F/0x41E/0x41C for the legacy region and 0x514/0x516 for the mode region. An off-by-one decoder there would either forward a stray access or drop a legal one.

On the byte-order word, it writes near-miss values and expects the selection to stay unchanged. A loose compare would flip the mode on those values. It also toggles `ext_en` and issues halfword extension accesses. A decoder that ignored the enable or the size would answer those with live data.

The back ends acknowledge after random delays. A bridge that raised ready too early would show too few logged byte operations at the moment ready arrives.

// File: rtl/mmio_win_bridge.sv
module mmio_win_bridge #(
  parameter int          LEG_BASE  = 12'h400,
  parameter int          LEG_SPAN  = 32,
  parameter int          PORT_W    = 10,
  parameter int          PORT_BASE = 10'h3C0,
  parameter int          MODE_BASE = 12'h500,
  parameter int          MODE_REGS = 11,
  parameter int          EXT_BASE  = 12'h600,
  parameter logic [31:0] BE_MAGIC  = 32'hBEBEBEBE,
  parameter logic [31:0] LE_MAGIC  = 32'h1E1E1E1E,
  parameter int          DEF_REV   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              ext_en,
  output logic [7:0]        rev_id,
  output logic              big_endian,
  output logic              lp_req,
  output logic              lp_we,
  output logic [PORT_W-1:0] lp_port,
  output logic [7:0]        lp_wdata,
  input  logic              lp_ack,
  input  logic [7:0]        lp_rdata,
  output logic              mr_idx_wr,
  output logic [$clog2(MODE_REGS)-1:0] mr_idx,
  output logic              mr_req,
  output logic              mr_we,
  output logic [15:0]       mr_wdata,
  input  logic              mr_ack,
  input  logic [15:0]       mr_rdata
);
  localparam int IDX_W  = $clog2(MODE_REGS);
  localparam int LOFF_W = $clog2(LEG_SPAN);
  localparam logic [31:0] EXT_SIZE = 32'd8;

  typedef enum logic [1:0] {S_IDLE, S_LEG, S_MIDX, S_MDAT} st_t;
  st_t st;

  logic [2:0]  nb;
  logic [12:0] loff, moff;
  logic        in_leg, in_mode, in_ext;
  logic        we;
  logic [31:0] wd, rd;
  logic [1:0]  cnt, last;
  logic [PORT_W-1:0] port;
  logic [IDX_W-1:0]  idx;

  assign nb      = 3'd1 << req_size;
  assign loff    = {1'b0, req_addr} - 13'(LEG_BASE);
  assign moff    = {1'b0, req_addr} - 13'(MODE_BASE);
  assign in_leg  = (req_size != 2'd3) && (({1'b0, loff} + 14'(nb)) <= 14'(LEG_SPAN));
  assign in_mode = moff < 13'(2 * MODE_REGS);
  assign in_ext  = ext_en && (req_size == 2'd2) &&
                   ((req_addr == 12'(EXT_BASE)) || (req_addr == 12'(EXT_BASE + 4)));

  assign rev_id    = ext_en ? 8'd2 : 8'(DEF_REV);
  assign rsp_rdata = rd;
  assign lp_req    = (st == S_LEG);
  assign lp_we     = we;
  assign lp_port   = port;
  assign lp_wdata  = wd[7:0];
  assign mr_idx_wr = (st == S_MIDX);
  assign mr_idx    = idx;
  assign mr_req    = (st == S_MDAT);
  assign mr_we     = we;
  assign mr_wdata  = wd[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rsp_ready <= 1'b0; big_endian <= 1'b0; we <= 1'b0;
      wd <= '0; rd <= '0; cnt <= '0; last <= '0; port <= '0; idx <= '0;
    end else begin
      rsp_ready <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          we <= req_write;
          wd <= req_wdata;
          rd <= '0;
          if (in_leg) begin
            st   <= S_LEG;
            port <= PORT_W'(PORT_BASE) + PORT_W'(loff[LOFF_W-1:0]);
            cnt  <= '0;
            last <= 2'(nb - 3'd1);
          end else if (in_mode) begin
            st  <= S_MIDX;
            idx <= moff[IDX_W:1];
          end else begin
            rsp_ready <= 1'b1;
            if (in_ext) begin
              if (req_addr[2]) begin
                rd <= big_endian ? BE_MAGIC : LE_MAGIC;
                if (req_write && req_wdata == BE_MAGIC) big_endian <= 1'b1;
                else if (req_write && req_wdata == LE_MAGIC) big_endian <= 1'b0;
              end else begin
                rd <= EXT_SIZE;
              end
            end
          end
        end
        S_LEG: if (lp_ack) begin
          rd[{cnt, 3'b000} +: 8] <= lp_rdata;
          wd   <= {8'd0, wd[31:8]};
          port <= port + 1'b1;
          cnt  <= cnt + 1'b1;
          if (cnt == last) begin
            st <= S_IDLE; rsp_ready <= 1'b1;
          end
        end
        S_MIDX: st <= S_MDAT;
        S_MDAT: if (mr_ack) begin
          rd <= {16'd0, mr_rdata};
          st <= S_IDLE; rsp_ready <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);
  a_r12_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (st == S_IDLE));
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req && !lp_ack |=> lp_req && $stable(lp_port) && $stable(lp_wdata));
  a_r5_ports_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req && lp_ack |=> !lp_req || (lp_port == $past(lp_port) + 1'b1));
  a_r6_index_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    mr_idx_wr |=> mr_req && $stable(mr_idx));
  a_r6_data_after_index: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_req) |-> $past(mr_idx_wr));
  a_r8_magic_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(big_endian) |-> $past(req_valid && req_write && ext_en && req_size == 2'd2 &&
      req_addr == 12'(EXT_BASE + 4) && (req_wdata == BE_MAGIC || req_wdata == LE_MAGIC)));
endmodule

// File: tb/test_mmio_win_bridge.sv
module test_mmio_win_bridge;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ext_en = 1;
  logic [11:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  logic rsp_ready, big_endian, lp_req, lp_we, lp_ack = 0, mr_idx_wr, mr_req, mr_we, mr_ack = 0;
  logic [7:0] rev_id, lp_wdata, lp_rdata = 0;
  logic [9:0] lp_port;
  logic [3:0] mr_idx;
  logic [15:0] mr_wdata, mr_rdata = 0;

  int checks = 0, fails = 0;
  logic [7:0]  lmem [32];
  logic [15:0] mregs [11];
  int   log_n = 0, mode_ops = 0, idx_log = 0;
  logic [9:0] log_port [8];
  logic [7:0] log_data [8];
  logic       log_we [8];
  bit   idx_seen = 0, order_ok = 0, exp_be = 0;

  always #4 clk = ~clk;

  mmio_win_bridge i_mmio_win_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ext_en(ext_en), .rev_id(rev_id),
    .big_endian(big_endian), .lp_req(lp_req), .lp_we(lp_we), .lp_port(lp_port),
    .lp_wdata(lp_wdata), .lp_ack(lp_ack), .lp_rdata(lp_rdata), .mr_idx_wr(mr_idx_wr),
    .mr_idx(mr_idx), .mr_req(mr_req), .mr_we(mr_we), .mr_wdata(mr_wdata),
    .mr_ack(mr_ack), .mr_rdata(mr_rdata));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : legacy_model
    int dly = 0;
    forever begin
      @(negedge clk);
      if (lp_ack) lp_ack = 0;
      else if (lp_req) begin
        if (dly == 0) begin
          if (log_n < 8) begin
            log_port[log_n] = lp_port; log_data[log_n] = lp_wdata; log_we[log_n] = lp_we;
          end
          log_n++;
          lp_rdata = lmem[5'(lp_port - 10'h3C0)];
          if (lp_we) lmem[5'(lp_port - 10'h3C0)] = lp_wdata;
          lp_ack = 1;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  initial begin : mode_model
    int dly = 0;
    logic [3:0] cur = 0;
    forever begin
      @(negedge clk);
      if (mr_ack) mr_ack = 0;
      else if (mr_idx_wr) begin cur = mr_idx; idx_seen = 1; end
      else if (mr_req) begin
        if (dly == 0) begin
          mode_ops++; idx_log = cur; order_ok = idx_seen; idx_seen = 0;
          mr_rdata = (cur < 11) ? mregs[cur] : 16'hDEAD;
          if (mr_we && cur < 11) mregs[cur] = mr_wdata;
          mr_ack = 1;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  function automatic int region(input logic [11:0] a, input logic [1:0] sz, input bit en);
    int nb = 1 << sz;
    if (sz != 3 && a >= 12'h400 && int'(a) - 'h400 + nb <= 32) return 1;
    if (a >= 12'h500 && a < 12'h516) return 2;
    if (en && sz == 2 && (a == 12'h600 || a == 12'h604)) return 3;
    return 0;
  endfunction

  task automatic access(input bit w, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
    int reg_k = region(a, sz, ext_en);
    int nb = 1 << sz;
    logic [31:0] exp_rd = 0;
    int off, lat = 0, mi;
    bit be_before = exp_be;
    log_n = 0; mode_ops = 0;
    if (reg_k == 1) begin
      off = int'(a) - 'h400;
      for (int k = 0; k < nb; k++) exp_rd[8*k +: 8] = lmem[off + k];
    end else if (reg_k == 2) begin
      mi = (int'(a) - 'h500) >> 1;
      exp_rd = {16'd0, mregs[mi]};
    end else if (reg_k == 3) begin
      exp_rd = (a == 12'h600) ? 32'd8 : (exp_be ? 32'hBEBEBEBE : 32'h1E1E1E1E);
      if (w && a == 12'h604 && d == 32'hBEBEBEBE) exp_be = 1;
      if (w && a == 12'h604 && d == 32'h1E1E1E1E) exp_be = 0;
    end
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_ready && lat < 100) begin @(negedge clk); lat++; end
    chk(rsp_ready, "R12 ready arrives", {31'd0, rsp_ready}, 1);
    @(negedge clk);
    chk(!rsp_ready, "R12 ready single pulse", {31'd0, rsp_ready}, 0);
    case (reg_k)
      1: begin
        chk(log_n == nb, "R2/R3/R5 legacy op count", log_n, nb);
        for (int k = 0; k < nb && k < log_n; k++) begin
          chk(log_port[k] == 10'(10'h3C0 + off + k), "R3/R5 port order low first",
              {22'd0, log_port[k]}, 32'h3C0 + off + k);
          chk(log_we[k] == w, "R2 legacy direction", log_we[k], w);
          if (w) chk(log_data[k] == d[8*k +: 8], "R3/R5 byte lane", log_data[k], d[8*k +: 8]);
        end
        chk(mode_ops == 0, "R2 no mode op", mode_ops, 0);
        if (!w) chk(rsp_rdata == exp_rd, "R4/R5 legacy read assembly", rsp_rdata, exp_rd);
      end
      2: begin
        chk(mode_ops == 1 && order_ok, "R6 index before data", mode_ops, 1);
        chk(idx_log == mi, "R6 index from address", idx_log, mi);
        chk(log_n == 0, "R6 no legacy op", log_n, 0);
        if (!w) chk(rsp_rdata == exp_rd, "R6 mode read", rsp_rdata, exp_rd);
        else chk(mregs[mi] == d[15:0], "R6 mode write", mregs[mi], d[15:0]);
      end
      3: begin
        if (!w) chk(rsp_rdata == exp_rd, "R7/R8 extension read", rsp_rdata, exp_rd);
        chk(big_endian == exp_be, "R8 byte-order select", big_endian, exp_be);
      end
      default: begin
        chk(lat == 0, "R11 unmapped latency", lat, 0);
        chk(log_n == 0 && mode_ops == 0, "R11 no back-end op", log_n + mode_ops, 0);
        if (!w) chk(rsp_rdata == 0, "R9/R11 unmapped reads zero", rsp_rdata, 0);
        chk(big_endian == be_before, "R9 no byte-order change", big_endian, be_before);
      end
    endcase
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin : main
    logic [31:0] d;
    logic [11:0] a;
    logic [1:0] sz;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) lmem[i] = 8'($urandom);
    for (int i = 0; i < 11; i++) mregs[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_ready && !lp_req && !mr_req && !mr_idx_wr, "R1 idle outputs", {rsp_ready, lp_req, mr_req, mr_idx_wr}, 0);
    chk(big_endian == 0, "R1 little-endian after reset", big_endian, 0);
    chk(rev_id == 2, "R10 revision enabled", rev_id, 2);
    access(0, 12'h604, 2, 0);
    access(0, 12'h600, 2, 0);
    access(1, 12'h600, 2, 32'h55);
    access(0, 12'h600, 2, 0);
    access(1, 12'h604, 2, 32'hBEBEBEBF);
    access(1, 12'h604, 2, 32'hBEBEBEBE);
    access(0, 12'h604, 2, 0);
    access(1, 12'h604, 2, 32'h1E1E1E1F);
    access(1, 12'h604, 2, 32'h1E1E1E1E);
    access(0, 12'h604, 1, 0);
    access(1, 12'h604, 1, 32'hBEBEBEBE);
    ext_en = 0;
    @(negedge clk);
    chk(rev_id == 1, "R10 revision disabled", rev_id, 1);
    access(0, 12'h600, 2, 0);
    access(1, 12'h604, 2, 32'hBEBEBEBE);
    ext_en = 1;
    access(1, 12'h404, 1, 32'h0000A511);
    access(0, 12'h404, 1, 0);
    access(0, 12'h41F, 0, 0);
    access(1, 12'h41C, 2, 32'h44332211);
    access(0, 12'h41C, 2, 0);
    access(1, 12'h41E, 2, 32'hFFFFFFFF);
    access(0, 12'h41F, 1, 0);
    access(1, 12'h514, 1, 16'h7A7A);
    access(0, 12'h515, 0, 0);
    access(1, 12'h516, 1, 16'h1234);
    access(0, 12'h000, 2, 0);
    access(0, 12'hFFF, 0, 0);
    access(0, 12'h400, 3, 0);
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 5)
        0: a = 12'h400 + 12'($urandom % 34);
        1: a = 12'h500 + 12'($urandom % 24);
        2: a = 12'h600 + 12'(($urandom % 3) * 4);
        3: a = 12'h5FE + 12'($urandom % 12);
        default: a = 12'($urandom);
      endcase
      sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      case ($urandom % 4)
        0: d = 32'hBEBEBEBE;
        1: d = 32'h1E1E1E1E;
        default: d = $urandom;
      endcase
      if ($urandom % 20 == 0) ext_en = ~ext_en;
      access(1'($urandom), a, sz, d);
    end
    finish_run();
  end
endmodule